// File: doc/BRIEF.md
# Configurable Depuncturing Unit

This block sits in front of a rate 1/2 convolutional decoder. The channel sends only some of the code bits, following one of five periodic deletion patterns. The block takes the 3-bit soft symbols that survived and rebuilds the full stream of symbol pairs. Each pair carries a first-row value and a second-row value. Positions that the pattern deleted are filled with a neutral soft value, and an erasure flag is raised beside them so the decoder can give them zero weight.

Received symbols arrive two at a time, an in-phase and a quadrature value, through a ready/valid handshake. Pairs leave through a second ready/valid handshake, one pair per decoder bit. Over a full pattern period, the number of pairs out per input transfer is 1, 4/3, 3/2, 5/3 or 7/4. Two control inputs, the code rate and a framing offset, select the deletion pattern and the column at which it starts. Changing either of them restarts the pattern and throws away any symbols still held. A holding store of three symbols bridges the two rates.

Top module: `depuncture_unit`

## Requirements
- R1: `code_rate` selects one pattern per row. Codes 0..4 mean rates 1/2, 2/3, 3/4, 5/6 and 7/8. Each row is written as column 0 first, and 1 means the position is present. The first row uses 1, 11, 110, 11010, 1111010 and the second row uses 1, 10, 101, 10101, 1000101. The column advances by one per output pair and wraps after the last column of the period.
- R2: Held symbols are used in arrival order: `in_i` before `in_q`, and each transfer after the one before it. Within a column, the first-row position takes a symbol before the second-row position.
- R3: A deleted position outputs the value 4 with its erasure flag at 1. A present position has its flag at 0. At least one position of every pair is present.
- R4: Rate codes 5, 6 and 7 behave exactly like code 0 (rate 1/2).
- R5: After a restart the first pair uses column `frame_ofs`. When `frame_ofs` is not less than the period, the first pair uses column 0.
- R6: A change of the effective rate or of `frame_ofs` discards every held symbol and restarts at the column from R5. In the cycle where the change is seen, `in_ready` and `out_valid` are both 0.
- R7: `in_ready` is 1 exactly when at most one symbol remains held after this cycle's output transfer. This includes a cycle in which a pair leaves and a new transfer is taken together.
- R8: `out_valid` is 1 only when enough symbols are held for the current column. While `out_ready` is 0, the offered pair and flags stay unchanged and `out_valid` stays 1.
- R9: While reset is asserted, and in the first cycle after it is released, `in_ready` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| code_rate | input | 3 | Code rate select (R1, R4) |
| frame_ofs | input | 3 | Starting column within the pattern period |
| in_valid | input | 1 | A received symbol pair is offered |
| in_ready | output | 1 | The block takes the offered pair this cycle |
| in_i | input | 3 | Earlier received soft symbol of the pair |
| in_q | input | 3 | Later received soft symbol of the pair |
| out_valid | output | 1 | A rebuilt pair is offered |
| out_ready | input | 1 | The decoder takes the pair this cycle |
| out_a | output | 3 | First-row soft value |
| out_era_a | output | 1 | First-row position was deleted |
| out_b | output | 3 | Second-row soft value |
| out_era_b | output | 1 | Second-row position was deleted |

## Verification
The bench sweeps every rate code against every framing offset, with random stalls on both handshakes, and predicts each pair from the pattern strings and the log of accepted symbols.

- An offset beyond the period exposes a design that does not clamp the start column. Its first pair would come from a column outside the pattern.
- Restarting with symbols still held exposes a design that does not flush. Its early pairs would be built from stale symbols.
- A long output stall exposes a design that overfills its store or moves its outputs while waiting.
- A transfer in the same cycle as a pair leaving exposes a design that cannot take both at once. It would lower `in_ready` in that cycle and lose throughput.

// File: rtl/dp_pkg.sv
package dp_pkg;

  localparam int unsigned SOFT_W     = 3;
  localparam int unsigned MAX_PERIOD = 7;
  localparam int unsigned COL_W      = $clog2(MAX_PERIOD + 1);

  typedef logic [COL_W-1:0] col_t;

  typedef enum logic [2:0] {
    CR_1_2 = 3'd0,
    CR_2_3 = 3'd1,
    CR_3_4 = 3'd2,
    CR_5_6 = 3'd3,
    CR_7_8 = 3'd4
  } code_rate_e;

  // Codes outside the five defined rates fall back to rate 1/2.
  function automatic code_rate_e norm_rate(input logic [2:0] code);
    if (code > 3'd4) return CR_1_2;
    return code_rate_e'(code);
  endfunction

  function automatic col_t period_of(input code_rate_e r);
    case (r)
      CR_2_3:  return col_t'(2);
      CR_3_4:  return col_t'(3);
      CR_5_6:  return col_t'(5);
      CR_7_8:  return col_t'(7);
      default: return col_t'(1);
    endcase
  endfunction

  // Presence mask of one row; bit k belongs to column k.
  function automatic logic [MAX_PERIOD-1:0] row_mask(input code_rate_e r, input logic second);
    logic [MAX_PERIOD-1:0] m;
    case (r)
      CR_2_3:  m = second ? 7'b0000001 : 7'b0000011;
      CR_3_4:  m = second ? 7'b0000101 : 7'b0000011;
      CR_5_6:  m = second ? 7'b0010101 : 7'b0001011;
      CR_7_8:  m = second ? 7'b1010001 : 7'b0101111;
      default: m = 7'b0000001;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/dp_punct_map.sv
module dp_punct_map
  import dp_pkg::*;
(
  input  code_rate_e rate,
  input  col_t       col,
  output logic       keep_a,
  output logic       keep_b,
  output col_t       period
);

  logic [1:0] keep;

  for (genvar r = 0; r < 2; r++) begin : g_row
    logic [MAX_PERIOD-1:0] mask;
    always_comb begin
      mask    = row_mask(rate, r[0]);
      keep[r] = mask[col];
    end
  end

  assign keep_a = keep[0];
  assign keep_b = keep[1];
  assign period = period_of(rate);

endmodule

// File: rtl/dp_col_ctr.sv
module dp_col_ctr
  import dp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  col_t start,
  input  logic adv,
  input  col_t period,
  output col_t col
);

  col_t col_q, col_d;
  logic col_en;
  logic at_last;

  assign at_last = (col_q == period - col_t'(1));

  always_comb begin
    col_en = load | adv;
    col_d  = col_q;
    if (load)         col_d = start;
    else if (adv)     col_d = at_last ? col_t'(0) : col_q + col_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      col_q <= '0;
    else if (col_en) col_q <= col_d;
  end

  assign col = col_q;

  // R1
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |-> col_q < period);

  // R1
  col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && at_last) |=> col_q == '0);

endmodule

// File: rtl/dp_sym_buf.sv
module dp_sym_buf #(
  parameter int unsigned SW    = 3,
  parameter int unsigned DEPTH = 3,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [1:0]       pop_n,
  input  logic             push,
  input  logic [SW-1:0]    in0,
  input  logic [SW-1:0]    in1,
  output logic [SW-1:0]    head0,
  output logic [SW-1:0]    head1,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic             buf_en;
  logic [SW-1:0]    ent_rd [DEPTH];

  always_comb begin
    base   = cnt_q - CNT_W'(pop_n);
    buf_en = flush | push | (pop_n != 2'd0);
    if (flush)     cnt_d = '0;
    else if (push) cnt_d = base + CNT_W'(2);
    else           cnt_d = base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (buf_en) cnt_q <= cnt_d;
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    logic [SW-1:0] ent_q, ent_d, sh1, sh2;

    if (k + 1 < DEPTH) begin : g_s1
      assign sh1 = ent_rd[k+1];
    end else begin : g_z1
      assign sh1 = '0;
    end
    if (k + 2 < DEPTH) begin : g_s2
      assign sh2 = ent_rd[k+2];
    end else begin : g_z2
      assign sh2 = '0;
    end

    always_comb begin
      case (pop_n)
        2'd1:    ent_d = sh1;
        2'd2:    ent_d = sh2;
        default: ent_d = ent_q;
      endcase
      if (push && base == CNT_W'(k))                       ent_d = in0;
      else if (push && (base + CNT_W'(1)) == CNT_W'(k))    ent_d = in1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (buf_en) ent_q <= ent_d;
    end

    assign ent_rd[k] = ent_q;
  end

  assign head0 = ent_rd[0];
  assign head1 = ent_rd[1];
  assign cnt   = cnt_q;

  // R8
  pop_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(pop_n) <= cnt_q);

  // R7
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q - CNT_W'(pop_n)) <= CNT_W'(DEPTH - 2));

endmodule

// File: rtl/depuncture_unit.sv
module depuncture_unit
  import dp_pkg::*;
#(
  parameter int unsigned SOFT_BITS = dp_pkg::SOFT_W,
  parameter int unsigned BUF_DEPTH = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           code_rate,
  input  logic [COL_W-1:0]     frame_ofs,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SOFT_BITS-1:0] in_i,
  input  logic [SOFT_BITS-1:0] in_q,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [SOFT_BITS-1:0] out_a,
  output logic                 out_era_a,
  output logic [SOFT_BITS-1:0] out_b,
  output logic                 out_era_b
);

  localparam int unsigned CNT_W = $clog2(BUF_DEPTH + 1);
  localparam logic [SOFT_BITS-1:0] NEUTRAL = {1'b1, {(SOFT_BITS-1){1'b0}}};
  localparam logic [2:0] RATE_NONE = 3'b111;

  // Reset synchronizer: asynchronous assertion, synchronous release.
  logic rst_meta_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  code_rate_e       rate_n;
  logic [2:0]       rate_q;
  col_t             ofs_q;
  logic             cfg_change;
  logic             keep_a, keep_b;
  col_t             period, col, start;
  logic [1:0]       need, pop_n;
  logic [CNT_W-1:0] cnt, cnt_after;
  logic [SOFT_BITS-1:0] head0, head1;
  logic             fire, push;

  assign rate_n = norm_rate(code_rate);

  always_comb begin
    cfg_change = (rate_q != 3'(rate_n)) || (ofs_q != frame_ofs);
    start      = (frame_ofs < period) ? frame_ofs : col_t'(0);
  end

  // Configuration tracking; the sentinel forces a restart after reset.
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rate_q <= RATE_NONE;
      ofs_q  <= '0;
    end else if (cfg_change) begin
      rate_q <= 3'(rate_n);
      ofs_q  <= frame_ofs;
    end
  end

  dp_punct_map u_map (
    .rate   (rate_n),
    .col    (col),
    .keep_a (keep_a),
    .keep_b (keep_b),
    .period (period)
  );

  dp_col_ctr u_col (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load   (cfg_change),
    .start  (start),
    .adv    (fire),
    .period (period),
    .col    (col)
  );

  always_comb begin
    need      = {1'b0, keep_a} + {1'b0, keep_b};
    out_valid = !cfg_change && (cnt >= CNT_W'(need));
    fire      = out_valid && out_ready;
    pop_n     = fire ? need : 2'd0;
    cnt_after = cnt - CNT_W'(pop_n);
    in_ready  = !cfg_change && (cnt_after <= CNT_W'(BUF_DEPTH - 2));
    push      = in_valid && in_ready;
  end

  dp_sym_buf #(
    .SW    (SOFT_BITS),
    .DEPTH (BUF_DEPTH)
  ) u_buf (
    .clk   (clk),
    .rst_n (rst_n_s),
    .flush (cfg_change),
    .pop_n (pop_n),
    .push  (push),
    .in0   (in_i),
    .in1   (in_q),
    .head0 (head0),
    .head1 (head1),
    .cnt   (cnt)
  );

  always_comb begin
    out_era_a = !keep_a;
    out_era_b = !keep_b;
    out_a     = keep_a ? head0 : NEUTRAL;
    if (!keep_b)     out_b = NEUTRAL;
    else if (keep_a) out_b = head1;
    else             out_b = head0;
  end

  // R3
  one_kept_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_valid |-> !(out_era_a && out_era_b));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && !out_ready) |=> cfg_change ||
      (out_valid && $stable(out_a) && $stable(out_b) &&
       $stable(out_era_a) && $stable(out_era_b)));

endmodule

// File: tb/sim_depuncture_unit.sv
`timescale 1ns/1ps
module sim_depuncture_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] code_rate, frame_ofs;
  logic       in_valid, in_ready, out_valid, out_ready;
  logic [2:0] in_i, in_q, out_a, out_b;
  logic       out_era_a, out_era_b;

  always #2 clk = ~clk;

  depuncture_unit u0 (
    .clk(clk), .rst_n(rst_n), .code_rate(code_rate), .frame_ofs(frame_ofs),
    .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_a(out_a), .out_era_a(out_era_a), .out_b(out_b), .out_era_b(out_era_b)
  );

  int vecs = 0;
  int miss = 0;
  bit finished = 0;

  string pat_a [5] = '{"1", "11", "110", "11010", "1111010"};
  string pat_b [5] = '{"1", "10", "101", "10101", "1000101"};

  logic [2:0] sent [1024];
  int wr, rd, mcol, mper, mre;
  logic [15:0] lf = 16'hACE1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int r, input int o);
    @(negedge clk);
    in_valid = 0; out_ready = 0;
    code_rate = 3'(r); frame_ofs = 3'(o);
    #1;
    // R6: both handshakes closed in the change cycle
    check(!in_ready && !out_valid, "R6 restart cycle", {in_ready, out_valid}, 0);
    mre  = (r > 4) ? 0 : r;
    mper = pat_a[mre].len();
    mcol = (o < mper) ? o : 0;
    wr = 0; rd = 0;
  endtask

  task automatic run(input int n, input string tag);
    int outs = 0;
    int guard = 0;
    bit hold = 0;
    logic [7:0] prev;
    while (outs < n && guard < 4000) begin
      @(negedge clk);
      guard++;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      in_valid  = lf[0] | lf[3];
      in_i      = lf[6:4];
      in_q      = lf[9:7];
      out_ready = lf[1] | lf[11];
      #1;
      if (hold)
        // R8: stalled pair unchanged
        check(out_valid && {out_a, out_era_a, out_b, out_era_b} == prev,
              "R8 stall hold", {out_a, out_era_a, out_b, out_era_b}, prev);
      hold = out_valid && !out_ready;
      prev = {out_a, out_era_a, out_b, out_era_b};
      if (out_valid && out_ready) begin
        bit ka, kb;
        logic [2:0] ea, eb;
        ka = (pat_a[mre][mcol] == "1");
        kb = (pat_b[mre][mcol] == "1");
        ea = 3'd4; eb = 3'd4;
        if (ka) begin ea = sent[rd]; rd++; end
        if (kb) begin eb = sent[rd]; rd++; end
        // R1 R2 R3 (tag adds R4/R5)
        check(out_a == ea && out_era_a == !ka, {tag, " first row"}, {out_era_a, out_a}, {!ka, ea});
        check(out_b == eb && out_era_b == !kb, {tag, " second row"}, {out_era_b, out_b}, {!kb, eb});
        mcol = (mcol + 1) % mper;
        outs++;
      end
      if (in_valid && in_ready) begin
        sent[wr] = in_i; sent[wr+1] = in_q; wr += 2;
      end
    end
    check(outs == n, {tag, " progress"}, outs, n);
  endtask

  initial begin
    rst_n = 0; code_rate = 0; frame_ofs = 0;
    in_valid = 0; out_ready = 0; in_i = 0; in_q = 0;
    #10;
    // R9: closed while in reset
    check(!in_ready && !out_valid, "R9 in reset", {in_ready, out_valid}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); @(negedge clk); #1;
    check(!in_ready && !out_valid, "R9 first cycle after release", {in_ready, out_valid}, 0);
    @(negedge clk); #1;
    check(in_ready && !out_valid, "R9 idle after restart", {in_ready, out_valid}, 2);

    // R7: output stalled, store fills to one pair and closes
    set_cfg(0, 1);
    begin
      int acc = 0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        in_valid = 1; in_i = 3'(c); in_q = 3'(c + 1); out_ready = 0;
        #1;
        if (in_ready) acc++;
      end
      check(acc == 1, "R7 accepts under stall", acc, 1);
      check(out_valid && out_a == 3'd0 && out_b == 3'd1, "R5 offset past period uses column 0",
            {out_a, out_b}, 1);
      @(negedge clk);
      out_ready = 1; in_valid = 1;
      #1;
      check(in_ready, "R7 take and give same cycle", in_ready, 1);
    end

    for (int r = 0; r < 5; r++)
      for (int o = 0; o < 8; o++) begin
        set_cfg(r, o);
        run(20, (o == 0) ? "R1 R2 R3 R6" : "R5 R1 R2 R3");
      end
    set_cfg(5, 0); run(16, "R4 code 5");
    set_cfg(5, 3); run(16, "R4 code 5 offset");
    set_cfg(6, 0); run(16, "R4 code 6");
    set_cfg(7, 2); run(16, "R4 code 7");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      vecs++; miss++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

endmodule